// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog timer driven by a slow oscillator. The oscillator reaches the block as a one-cycle enable, `osc_tick`, in the system clock domain. While the watchdog is on, it counts those ticks. If the selected period passes without a `kick`, it issues a one-cycle `wdt_reset_req`. Software restarts the count by pulsing `kick`, which stands in for the watchdog-restart instruction.

An 8-bit control register is written and read over a plain register port. Writes are single-cycle strobes, accepted in the cycle they are presented, so the port has no back-pressure. The register holds:
- an enable flag,
- a three-bit period code,
- a change-window flag.

Turning the watchdog off takes two writes. The first write sets the change flag and the enable flag together, which opens a window of four clock cycles. The second write, made inside that window, clears the enable flag. When `safe_mode` is high, the period code is guarded by the same window.

Top module: `wdt_guard`

## Requirements
- R1: After reset `cfg_rd_data` reads 0x00: watchdog off, period code 0, change window closed. `wdt_reset_req` is low.
- R2: `cfg_rd_data` reads back the register as follows: bits 7..5 are always 0, bit 4 is the change-window flag, bit 3 is the enable flag, and bits 2..0 are the period code. Write data uses the same bit positions.
- R3: Period code p (0..7) selects a timeout of 2^(BASE_LOG2+p) ticks, so each step doubles the timeout. With the default BASE_LOG2 = 14, code 0 gives 16,384 ticks and code 7 gives 2,097,152 ticks. The request follows the tick that completes the period.
- R4: A write with bit 4 = 1 and bit 3 = 1 opens the change window. The flag then reads 1 for exactly four cycles and clears by itself. Repeating that write while the window is open restarts the four cycles.
- R5: While the window is closed, a write with bit 3 = 0 leaves the enable flag as it was.
- R6: A write with bit 3 = 0 made inside the window turns the watchdog off. While off, the count is held at zero and no request is issued.
- R7: A write with bit 3 = 1 always turns the watchdog on.
- R8: With `safe_mode` = 1, the period code changes only through a write made inside the window. With `safe_mode` = 0, every write loads the period code.
- R9: `kick` restarts the count from zero. A kick in the same cycle as the expiring tick suppresses the request.
- R10: `wdt_reset_req` is a single-cycle pulse, and counting restarts from zero after it.
- R11: Only cycles with `osc_tick` high advance the count.
- R12: If the period code is lowered below the count already reached, the next tick expires the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| safe_mode | input | 1 | 1 guards period-code writes with the change window |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control register read value |
| kick | input | 1 | Restart the watchdog count |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench probes the edges of the change window:
- A disable on the fourth cycle after the opening write must work.
- A disable one cycle later must be ignored.

A design with an off-by-one window counter fails one of these two cases.

It also probes the expiring tick itself:
- A kick in that same cycle must suppress the request; a design that gives expiry priority would reset the chip.
- A period code lowered below the running count must expire on the next tick; a design that compares for equality would wrap and miss the timeout.

Under `safe_mode`, period writes outside the window are attempted. A design that leaks the code through would show a changed read value and a changed timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W    = 3;
  localparam int NCODES  = 1 << PS_W;
  localparam int WIN_LEN = 4;
  localparam int WIN_W   = $clog2(WIN_LEN);

  typedef struct packed {
    logic [2:0]      rsv;
    logic            chg;
    logic            en;
    logic [PS_W-1:0] ps;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            safe_mode,
  input  logic            wr_en,
  input  wdt_cfg_t        wr_data,
  output logic            en_q,
  output logic            chg_q,
  output logic [PS_W-1:0] ps_q
);
  logic [WIN_W-1:0] win_left;
  logic             open_req;
  logic             unused_rsv;

  assign unused_rsv = ^wr_data.rsv;
  assign open_req   = wr_en && wr_data.chg && wr_data.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ps_q  <= '0;
    end else if (wr_en) begin
      if (chg_q) begin
        en_q <= wr_data.en;
        ps_q <= wr_data.ps;
      end else begin
        en_q <= en_q | wr_data.en;
        if (!safe_mode) ps_q <= wr_data.ps;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q    <= 1'b0;
      win_left <= '0;
    end else if (open_req) begin
      chg_q    <= 1'b1;
      win_left <= WIN_W'(WIN_LEN - 1);
    end else if (chg_q) begin
      if (win_left == '0) chg_q <= 1'b0;
      else                win_left <= win_left - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  localparam int LIM_W    = BASE_LOG2 + NCODES
) (
  input  logic [PS_W-1:0]  ps,
  output logic [LIM_W-1:0] last_cnt
);
  logic [LIM_W-1:0] lim_tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    assign lim_tab[g] = (LIM_W'(1) << (BASE_LOG2 + g)) - LIM_W'(1);
  end

  assign last_cnt = lim_tab[ps];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int LIM_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [LIM_W-1:0] last_cnt,
  output logic             expire
);
  logic [LIM_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= run && !kick && tick && at_end;
      if (!run || kick)  cnt <= '0;
      else if (tick)     cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       safe_mode,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  output logic [7:0] cfg_rd_data,
  input  logic       kick,
  input  logic       osc_tick,
  output logic       wdt_reset_req
);
  localparam int LIM_W = BASE_LOG2 + NCODES;

  logic            en_q, chg_q;
  logic [PS_W-1:0] ps_q;
  logic [LIM_W-1:0] last_cnt;
  wdt_cfg_t        rd_cfg;

  wdt_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .safe_mode(safe_mode),
    .wr_en(cfg_wr_en), .wr_data(wdt_cfg_t'(cfg_wr_data)),
    .en_q(en_q), .chg_q(chg_q), .ps_q(ps_q)
  );

  wdt_period_sel #(.BASE_LOG2(BASE_LOG2)) u_sel (
    .ps(ps_q), .last_cnt(last_cnt)
  );

  wdt_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_q), .kick(kick),
    .tick(osc_tick), .last_cnt(last_cnt), .expire(wdt_reset_req)
  );

  always_comb begin
    rd_cfg     = '0;
    rd_cfg.chg = chg_q;
    rd_cfg.en  = en_q;
    rd_cfg.ps  = ps_q;
  end
  assign cfg_rd_data = rd_cfg;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       safe_mode,
  input logic       wr_open,
  input logic       kick,
  input logic       osc_tick,
  input logic [7:0] cfg_rd_data,
  input logic       wdt_reset_req
);
  logic       chg, en;
  logic [2:0] ps;
  logic [2:0] chg_run;
  logic       open_d;

  assign chg = cfg_rd_data[4];
  assign en  = cfg_rd_data[3];
  assign ps  = cfg_rd_data[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_d  <= 1'b0;
      chg_run <= '0;
    end else begin
      open_d <= wr_open;
      if (chg && chg_run != 3'd7) chg_run <= chg_run + 1'b1;
      else if (!chg)              chg_run <= '0;
      if (open_d)                 chg_run <= 3'd1;
    end
  end

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[7:5] == 3'b000);
  p_win_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_run <= 3'd4);
  p_no_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !chg) |=> en);
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wdt_reset_req);
  p_ps_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_mode && !chg) |=> ps == $past(ps));
  p_kick_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdt_reset_req);
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);
  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> !wdt_reset_req);
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .safe_mode(safe_mode),
  .wr_open(cfg_wr_en && cfg_wr_data[4] && cfg_wr_data[3]),
  .kick(kick), .osc_tick(osc_tick),
  .cfg_rd_data(cfg_rd_data), .wdt_reset_req(wdt_reset_req)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       safe_mode = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       kick = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wdt_reset_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_en, m_chg, m_req;
  bit [2:0] m_ps;
  int m_win, m_cnt;

  always #2 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .safe_mode(safe_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .kick(kick), .osc_tick(osc_tick), .wdt_reset_req(wdt_reset_req)
  );

  function automatic int period(bit [2:0] p);
    return 1 << (BASE + p);
  endfunction

  function automatic bit [7:0] exp_rd();
    return {3'b000, m_chg, m_en, m_ps};
  endfunction

  task automatic model_step();
    bit expire_now;
    expire_now = m_en && !kick && osc_tick && (m_cnt >= period(m_ps) - 1);
    m_req = expire_now;
    if (!m_en || kick) m_cnt = 0;
    else if (osc_tick) m_cnt = expire_now ? 0 : m_cnt + 1;
    if (cfg_wr_en) begin
      if (m_chg) begin
        m_en = cfg_wr_data[3];
        m_ps = cfg_wr_data[2:0];
      end else begin
        m_en = m_en | cfg_wr_data[3];
        if (!safe_mode) m_ps = cfg_wr_data[2:0];
      end
    end
    if (cfg_wr_en && cfg_wr_data[4] && cfg_wr_data[3]) begin
      m_chg = 1; m_win = 3;
    end else if (m_chg) begin
      if (m_win == 0) m_chg = 0;
      else m_win--;
    end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (cfg_rd_data !== exp_rd()) begin
      n_fail++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, cfg_rd_data, exp_rd());
    end
    n_chk++;
    if (wdt_reset_req !== m_req) begin
      n_fail++;
      $display("FAIL %s reset_req actual=%0b expected=%0b", tag, wdt_reset_req, m_req);
    end
  endtask

  task automatic cyc(string tag, bit wr = 0, bit [7:0] d = 0, bit k = 0, bit t = 1);
    cfg_wr_en = wr; cfg_wr_data = d; kick = k; osc_tick = t;
    @(posedge clk);
    model_step();
    #1;
    check(tag);
  endtask

  task automatic idle(string tag, int n, bit t = 1);
    for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, t);
  endtask

  function automatic void finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = 0; m_chg = 0; m_req = 0; m_ps = 0; m_win = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 reset state");

    cyc("R7 enable code0", 1, 8'h08);
    idle("R3 code0 timeout", 40);
    idle("R10 pulse restart", 20);

    // kick on the expiring tick
    cyc("R9 kick restart", 0, 0, 1, 1);
    idle("R9 run to edge", 15);
    cyc("R9 kick beats expiry", 0, 0, 1, 1);
    idle("R11 no ticks", 30, 0);
    idle("R11 ticks again", 20);

    cyc("R5 clear without window", 1, 8'h00);
    idle("R5 still running", 5);

    safe_mode = 1;
    cyc("R8 locked code write", 1, 8'h0B);
    idle("R8 code unchanged", 3);
    safe_mode = 0;
    cyc("R8 open code write", 1, 8'h0B);
    idle("R3 code3 timeout", 140);

    cyc("R4 open window", 1, 8'h18);
    idle("R4 window expiry", 6);
    cyc("R4 open again", 1, 8'h18);
    idle("R4 wait", 4);
    cyc("R4 late disable ignored", 1, 8'h00);
    idle("R4 still on", 3);

    safe_mode = 1;
    cyc("R8 open in safe mode", 1, 8'h18);
    cyc("R8 code in window", 1, 8'h19);
    idle("R8 code held", 3);
    safe_mode = 0;

    cyc("R4 open for edge", 1, 8'h18);
    idle("R6 wait", 3);
    cyc("R6 disable on last cycle", 1, 8'h00);
    idle("R6 held off", 60);

    cyc("R7 enable code7", 1, 8'h0F);
    idle("R12 partial count", 100);
    cyc("R12 lower code", 1, 8'h08);
    idle("R12 early expiry", 3);
    cyc("R3 code7 again", 1, 8'h0F);
    idle("R3 code7 timeout", 2060);

    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      safe_mode = ($urandom_range(0, 3) == 0);
      if (r < 6)       cyc("R2 random", 1, 8'h18 | 8'($urandom_range(0, 7)));
      else if (r < 12) cyc("R2 random", 1, 8'($urandom_range(0, 255)) & 8'h17);
      else if (r < 16) cyc("R2 random", 1, 8'h08 | 8'($urandom_range(0, 2)), 0, 1);
      else if (r < 18) cyc("R2 random", 0, 0, 1, 1);
      else             cyc("R2 random", 0, 0, 0, ($urandom_range(0, 3) != 0));
    end
    finish_run();
  end
endmodule